// File: doc/BRIEF.md
# DMA Tag Group Completion Tracker

This block counts the DMA commands still in flight for each of 32 tag groups. The command queue pulses an increment with a 5-bit tag each time it accepts a command. The transfer engine pulses a completion with a tag each time a transfer ends. Any number of commands may share a tag. A group counts as idle only when every command carrying its tag has finished.

Software selects groups by writing a 32-bit query mask, in which bit n stands for tag n. It then places a status read request. The tracker holds the request open until every selected group is idle. It then raises a response valid, which stays up until software takes it with a ready. The response carries the status word, in which bit n is set when tag n is both selected and idle. If the mask changes while a request waits, the wait condition follows the new mask. A completion for a group that has nothing outstanding sets a sticky error flag and does not disturb the count.

Top module: `tagtrk_top`

## Requirements
- R1: After reset every group count is zero, the mask is zero, reqReady is 1, rspValid is 0, rspStatus is 0 and underflowErr is 0.
- R2: An incValid pulse adds one to the outstanding count of group incTag, and a doneValid pulse subtracts one from the count of group doneTag. A group with several outstanding commands becomes idle only after the last of them completes.
- R3: An increment and a completion for the same group in the same cycle leave that group's count unchanged and raise no error.
- R4: While no response is being held, rspStatus bit n equals mask bit n AND (count of group n is zero).
- R5: A request is accepted in a cycle with reqValid and reqReady both high. reqReady is 1 only when no request is open, so it drops in the cycle after an acceptance.
- R6: While a request is open, rspValid rises in the first cycle in which every group selected by the mask has a zero count. It does not rise earlier.
- R7: A request made while the mask is all zero gets rspValid in the cycle after acceptance, with rspStatus equal to 0.
- R8: A mask write, in which maskWrData is loaded when maskWrEn is 1, takes effect from the next cycle. This includes a write made while a request is open, and the wait condition is then evaluated against the new mask.
- R9: A completion for a group whose count is zero sets underflowErr, and the count stays at zero. underflowErr stays set until reset.
- R10: Once rspValid is high it stays high, and rspStatus keeps the status word captured at the first valid cycle, until a cycle with rspReady high. After that cycle the request is closed and reqReady returns to 1.
- R11: Tag value n maps to bit n of both the mask and the status word, for every n from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| incValid | input | 1 | A command was enqueued |
| incTag | input | 5 | Tag of the enqueued command |
| doneValid | input | 1 | A transfer finished |
| doneTag | input | 5 | Tag of the finished transfer |
| maskWrEn | input | 1 | Load a new query mask |
| maskWrData | input | 32 | Query mask value, bit n selects tag n |
| reqValid | input | 1 | Status read request |
| reqReady | output | 1 | Request can be accepted |
| rspValid | output | 1 | Status response available |
| rspReady | input | 1 | Response taken |
| rspStatus | output | 32 | Status word, bit n set when tag n is selected and idle |
| underflowErr | output | 1 | Sticky: completion arrived for an idle group |

## Verification
On every cycle the assertions check four things: a simultaneous increment and completion holds a count steady, a count never drops below zero, the error flag is sticky, and a held response stays valid until it is taken. They also check that the response is only captured when no selected group is busy. The bench runs a reference model beside the design. With it the bench shows what no single-cycle property can: that the status bits line up with the tags, that several commands on one tag must all drain, and that a mask rewrite releases a waiting read. It also shows that an all-zero mask answers at once, and that the captured word survives new traffic while the response waits.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;
  localparam int unsigned GROUPS = 32;
  localparam int unsigned TAG_W  = $clog2(GROUPS);

  typedef struct packed {
    logic [GROUPS-1:0] incHot;
    logic [GROUPS-1:0] decHot;
    logic              maskLoad;
    logic              capture;
    logic              showSnap;
  } strobes_t;
endpackage

// File: rtl/tagtrk_counter.sv
module tagtrk_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             isZero,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign isZero    = (count == '0);
  assign underflow = dec & ~inc & isZero;

  always_ff @(posedge clk) begin
    if (!rstN)                      count <= '0;
    else if (inc & ~dec)            count <= count + ONE;
    else if (dec & ~inc & ~isZero)  count <= count - ONE;
  end

  // R3: paired increment and completion keep the count
  p_pair_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inc && dec) |=> $stable(count));

  // R9: no wrap below zero
  p_floor_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dec && !inc && isZero) |=> isZero);

  // R2: single increment steps by one
  p_step_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !dec && count != '1) |=> count == $past(count) + ONE);
endmodule

// File: rtl/tagtrk_ctrl.sv
module tagtrk_ctrl
  import tagtrk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             incValid,
  input  logic [TAG_W-1:0] incTag,
  input  logic             doneValid,
  input  logic [TAG_W-1:0] doneTag,
  input  logic             maskWrEn,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             rspValid,
  input  logic             rspReady,
  input  logic             allIdle,
  output strobes_t         strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} state_t;
  state_t state, stateNext;

  localparam logic [GROUPS-1:0] BIT0 = GROUPS'(1);

  always_comb begin
    strb.incHot   = incValid  ? (BIT0 << incTag)  : '0;
    strb.decHot   = doneValid ? (BIT0 << doneTag) : '0;
    strb.maskLoad = maskWrEn;
    strb.capture  = (state == ST_WAIT) && allIdle && !rspReady;
    strb.showSnap = (state == ST_RESP);
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = ((state == ST_WAIT) && allIdle) || (state == ST_RESP);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_WAIT;
      ST_WAIT: if (allIdle)  stateNext = rspReady ? ST_IDLE : ST_RESP;
      ST_RESP: if (rspReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R10: a response stays offered until taken
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R5: an accepted request closes the request port
  p_accept_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: a taken response reopens the request port
  p_rsp_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> reqReady);
endmodule

// File: rtl/tagtrk_datapath.sv
module tagtrk_datapath
  import tagtrk_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [GROUPS-1:0] maskWrData,
  output logic              allIdle,
  output logic [GROUPS-1:0] rspStatus,
  output logic              underflowErr
);
  logic [GROUPS-1:0] maskQ;
  logic [GROUPS-1:0] busy;
  logic [GROUPS-1:0] underPulse;
  logic [GROUPS-1:0] liveStatus;
  logic [GROUPS-1:0] rspSnap;

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic [CNT_W-1:0] cnt;
    logic             zero;
    tagtrk_counter #(.CNT_W(CNT_W)) uCnt (
      .clk      (clk),
      .rstN     (rstN),
      .inc      (strb.incHot[g]),
      .dec      (strb.decHot[g]),
      .count    (cnt),
      .isZero   (zero),
      .underflow(underPulse[g])
    );
    assign busy[g] = ~zero;
  end

  assign liveStatus = maskQ & ~busy;
  assign allIdle    = ((maskQ & busy) == '0);
  assign rspStatus  = strb.showSnap ? rspSnap : liveStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ        <= '0;
      rspSnap      <= '0;
      underflowErr <= 1'b0;
    end else begin
      if (strb.maskLoad) maskQ   <= maskWrData;
      if (strb.capture)  rspSnap <= liveStatus;
      if (|underPulse)   underflowErr <= 1'b1;
    end
  end

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);

  // R6: capture only when the control saw every selected group idle
  p_capture_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> ((maskQ & busy) == '0));

  // R10: held status does not move while shown
  p_snap_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.showSnap && $past(strb.showSnap)) |-> $stable(rspStatus));
endmodule

// File: rtl/tagtrk_top.sv
module tagtrk_top
  import tagtrk_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              incValid,
  input  logic [TAG_W-1:0]  incTag,
  input  logic              doneValid,
  input  logic [TAG_W-1:0]  doneTag,
  input  logic              maskWrEn,
  input  logic [GROUPS-1:0] maskWrData,
  input  logic              reqValid,
  output logic              reqReady,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [GROUPS-1:0] rspStatus,
  output logic              underflowErr
);
  strobes_t strb;
  logic     allIdle;

  tagtrk_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .incValid (incValid),
    .incTag   (incTag),
    .doneValid(doneValid),
    .doneTag  (doneTag),
    .maskWrEn (maskWrEn),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .allIdle  (allIdle),
    .strb     (strb)
  );

  tagtrk_datapath #(.CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .maskWrData  (maskWrData),
    .allIdle     (allIdle),
    .rspStatus   (rspStatus),
    .underflowErr(underflowErr)
  );
endmodule

// File: tb/sim_tagtrk_top.sv
module sim_tagtrk_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, incValid, doneValid, maskWrEn, reqValid, rspReady;
  logic [4:0]  incTag, doneTag;
  logic [31:0] maskWrData, rspStatus;
  logic        reqReady, rspValid, underflowErr;

  tagtrk_top u0 (
    .clk(clk), .rstN(rstN), .incValid(incValid), .incTag(incTag),
    .doneValid(doneValid), .doneTag(doneTag), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady), .rspStatus(rspStatus),
    .underflowErr(underflowErr)
  );

  int vecs = 0, bad = 0;
  int refCnt[32];
  logic [31:0] refMask, refSnap;
  logic refErr;
  int refSt;
  logic pIv, pDv, pMw, pRq, pRr;
  logic [4:0] pIt, pDt;
  logic [31:0] pMd;

  function automatic logic [31:0] busyVec();
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = (refCnt[i] != 0);
    return b;
  endfunction

  function automatic logic [31:0] expStatus();
    return (refSt == 2) ? refSnap : (refMask & ~busyVec());
  endfunction

  function automatic logic expValid();
    return ((refSt == 1) && ((refMask & busyVec()) == 0)) || (refSt == 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic iv, input logic [4:0] it, input logic dv, input logic [4:0] dt,
                       input logic mw, input logic [31:0] md, input logic rq, input logic rr);
    @(negedge clk);
    incValid = iv; incTag = it; doneValid = dv; doneTag = dt;
    maskWrEn = mw; maskWrData = md; reqValid = rq; rspReady = rr;
    pIv = iv; pIt = it; pDv = dv; pDt = dt; pMw = mw; pMd = md; pRq = rq; pRr = rr;
    #1;
    chk(reqReady === (refSt == 0), "R5 reqReady", 32'(reqReady), 32'(refSt == 0));
    chk(rspValid === expValid(), "R6 rspValid", 32'(rspValid), 32'(expValid()));
    chk(rspStatus === expStatus(), "R4 rspStatus", rspStatus, expStatus());
    chk(underflowErr === refErr, "R9 underflowErr", 32'(underflowErr), 32'(refErr));
  endtask

  task automatic tick();
    logic allI;
    logic [31:0] live;
    allI = ((refMask & busyVec()) == 0);
    live = refMask & ~busyVec();
    case (refSt)
      0: if (pRq) refSt = 1;
      1: if (allI) begin
           if (pRr) refSt = 0;
           else begin refSt = 2; refSnap = live; end
         end
      default: if (pRr) refSt = 0;
    endcase
    if (!(pIv && pDv && pIt == pDt)) begin
      if (pIv) refCnt[pIt]++;
      if (pDv) begin
        if (refCnt[pDt] == 0) refErr = 1'b1;
        else refCnt[pDt]--;
      end
    end
    if (pMw) refMask = pMd;
    @(posedge clk);
  endtask

  task automatic cyc(input logic iv, input logic [4:0] it, input logic dv, input logic [4:0] dt,
                     input logic mw, input logic [31:0] md, input logic rq, input logic rr);
    drive(iv, it, dv, dt, mw, md, rq, rr);
    tick();
  endtask

  task automatic idle(input logic rr);
    cyc(0, 0, 0, 0, 0, 0, 0, rr);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 32; i++) refCnt[i] = 0;
    refMask = 0; refSnap = 0; refErr = 0; refSt = 0;
    rstN = 0; incValid = 0; incTag = 0; doneValid = 0; doneTag = 0;
    maskWrEn = 0; maskWrData = 0; reqValid = 0; rspReady = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset state
    #1;
    chk(reqReady === 1'b1, "R1 reqReady", 32'(reqReady), 1);
    chk(rspValid === 1'b0, "R1 rspValid", 32'(rspValid), 0);
    chk(rspStatus === 32'h0, "R1 rspStatus", rspStatus, 0);
    chk(underflowErr === 1'b0, "R1 underflowErr", 32'(underflowErr), 0);

    // R2/R11: three commands on tag 7
    cyc(0, 0, 0, 0, 1, 32'h80, 0, 0);
    repeat (3) cyc(1, 7, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspValid === 1'b0, "R2 wait busy", 32'(rspValid), 0); tick();
    cyc(0, 0, 1, 7, 0, 0, 0, 0);
    cyc(0, 0, 1, 7, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspValid === 1'b0, "R2 one left", 32'(rspValid), 0); tick();
    cyc(0, 0, 1, 7, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    chk(rspValid === 1'b1, "R2 drained", 32'(rspValid), 1);
    chk(rspStatus === 32'h80, "R11 bit7", rspStatus, 32'h80); tick();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(reqReady === 1'b1, "R10 reopened", 32'(reqReady), 1); tick();

    // R3: simultaneous inc and done on tag 5
    cyc(1, 5, 0, 0, 1, 32'h20, 0, 0);
    cyc(1, 5, 1, 5, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(underflowErr === 1'b0, "R3 no error", 32'(underflowErr), 0);
    chk(rspStatus[5] === 1'b0, "R3 still busy", 32'(rspStatus[5]), 0); tick();
    cyc(1, 5, 1, 5, 0, 0, 0, 0);
    cyc(0, 0, 1, 5, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspStatus === 32'h20, "R3 drained", rspStatus, 32'h20); tick();

    // R7: zero mask answers at once
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspValid === 1'b1, "R7 valid", 32'(rspValid), 1);
    chk(rspStatus === 32'h0, "R7 status", rspStatus, 0); tick();
    idle(1);

    // R8: mask rewrite releases a waiting read
    cyc(1, 3, 0, 0, 1, 32'h8, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 32'h10, 0, 0);
    chk(rspValid === 1'b0, "R8 before", 32'(rspValid), 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspValid === 1'b1, "R8 after", 32'(rspValid), 1);
    chk(rspStatus === 32'h10, "R8 status", rspStatus, 32'h10); tick();
    idle(1);
    cyc(0, 0, 1, 3, 0, 0, 0, 0);

    // R10: snapshot held against new traffic
    cyc(0, 0, 0, 0, 1, 32'h200, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 9, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspValid === 1'b1, "R10 held", 32'(rspValid), 1);
    chk(rspStatus === 32'h200, "R10 snapshot", rspStatus, 32'h200); tick();
    idle(1);
    cyc(0, 0, 1, 9, 0, 0, 0, 0);

    // R9: underflow is sticky, count stays zero
    cyc(0, 0, 1, 12, 1, 32'h1000, 0, 0);
    cyc(1, 12, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(underflowErr === 1'b1, "R9 flag", 32'(underflowErr), 1);
    chk(rspStatus[12] === 1'b0, "R9 count one", 32'(rspStatus[12]), 0); tick();
    cyc(0, 0, 1, 12, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk(rspStatus[12] === 1'b1, "R9 back to zero", 32'(rspStatus[12]), 1); tick();

    // R11: every tag maps to its own bit
    cyc(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    for (int k = 0; k < 32; k++) begin
      cyc(1, 5'(k), 0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      chk(rspStatus === ~(32'h1 << k), "R11 sweep", rspStatus, ~(32'h1 << k)); tick();
      cyc(0, 0, 1, 5'(k), 0, 0, 0, 0);
    end

    // mixed traffic against the model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 4000; n++) begin
      logic iv, dv, mw, rq, rr;
      logic [4:0] it, dt;
      logic [31:0] md;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      it = lfsr[4:0] & 5'h7;
      dt = lfsr[9:5] & 5'h7;
      iv = lfsr[10] & lfsr[11] & (refCnt[it] < 16);
      dv = lfsr[12] | lfsr[13];
      mw = (lfsr[17:14] == 4'h0);
      md = {24'h0, lfsr[25:18]} << lfsr[27:26];
      rq = lfsr[28];
      rr = lfsr[29] | lfsr[30];
      cyc(iv, it, dv, dt, mw, md, rq, rr);
    end

    finishRun();
  end
endmodule